// File: doc/BRIEF.md
# Round-Robin Bus Arbiter for a Shared PCI-Style Bus

This block decides which of five requesters may drive a shared PCI-style bus next. Requester 0 is the chip's own initiator and requesters 1 to 4 are external masters. Each requester has an active-low request line and an active-low grant line. The arbiter also watches the bus FRAME and IRDY lines. When both are high in a cycle, the bus is idle. A strap input switches the whole arbiter on or off.

Winners are picked in round-robin order. The search starts at the requester after the most recent grantee. While a transaction is running, the grant moves straight to the next winner, so arbitration is hidden behind the running transfer. On an idle bus, a requesting grantee keeps its grant long enough to start a transfer. A grantee that has dropped its request loses its grant only after a dead cycle in which no grant is driven, which leaves time for driver turnaround. With nobody requesting, the last grant stays parked.

A grantee that keeps requesting on an idle bus for 16 cycles without starting loses its grant. It is then shut out until it has raised its request for at least one cycle.

Top module: `pci_rr_arbiter`

## Requirements
- R1: After reset, every gnt_n bit is high, the round-robin search starts at requester 0, and no requester is shut out.
- R2: While arb_en is 0, all gnt_n bits are high from the next clock edge on, whatever the request lines do.
- R3: gnt_n has at most one bit low in any cycle, and gnt_n bit i is the grant for req_n bit i.
- R4: The winner is the first requester with req_n low and not shut out, searching upward with wrap-around from the index after the last grantee. With all five requesting on a busy bus, grants go 0, 1, 2, 3, 4, 0.
- R5: While the bus is busy (frame_n or irdy_n low), a change of grantee happens within one edge, with no cycle that has all gnt_n bits high.
- R6: On an idle bus (frame_n and irdy_n both high), a grant is never replaced in one edge. A cycle with all gnt_n bits high always comes between two different grants.
- R7: When no req_n bit is low, the current grant stays asserted (parking). This holds on an idle bus too, because a grantee that is not requesting is never timed out.
- R8: If a grantee holds its request through 16 consecutive idle cycles while granted, its grant is removed at the 16th such edge. Its gnt_n goes high at that edge and not earlier.
- R9: A requester whose grant was removed by R8 gets no grant until its req_n has been high for at least one cycle. After that it can win again.
- R10: On an idle bus, a grantee that keeps its req_n low keeps its grant, even when other requests are pending, until R8 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arb_en | input | 1 | Strap: 1 enables arbitration, 0 forces all grants off |
| req_n | input | 5 | Active-low requests; bit 0 is the internal initiator, bits 1 to 4 are the external masters |
| frame_n | input | 1 | Bus FRAME, active low |
| irdy_n | input | 1 | Bus IRDY, active low |
| gnt_n | output | 5 | Active-low registered grants, one bit per requester |

## Verification
A wrong round-robin pointer shows at the first contended edge after it goes wrong. On a busy bus with several requesters, gnt_n then moves to the wrong index one edge later. A lost or stuck shut-out flag shows as a timed-out master that is granted again while its req_n is still low, or that is never granted after it has raised and lowered it. The start counter is only visible at its 16th idle edge. An off-by-one there moves the release of gnt_n one cycle early or late, and the bench checks exactly that edge.

// File: rtl/pcarb_pkg.sv
package pcarb_pkg;

  // Per-edge decision of the grant controller
  typedef enum logic [2:0] {
    ARB_OFF,     // strap low: drop everything
    ARB_EXPIRE,  // start window ran out: drop and shut out grantee
    ARB_HOLD,    // idle bus, grantee still requesting: keep
    ARB_GRANT,   // nothing granted: hand to winner if any
    ARB_HIDDEN,  // busy bus: move grant straight to winner
    ARB_TURN,    // idle bus, grantee gone quiet, others waiting: dead cycle
    ARB_PARK     // nobody waiting: keep last grant
  } arb_dec_e;

endpackage

// File: rtl/pcarb_rst_sync.sv
module pcarb_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;

endmodule

// File: rtl/pcarb_rr_pick.sv
module pcarb_rr_pick #(
  parameter int NREQ  = 5,
  parameter int IDX_W = 3
) (
  input  logic [NREQ-1:0]  elig,
  input  logic [IDX_W-1:0] last,
  output logic             found,
  output logic [IDX_W-1:0] win
);

  int idx;

  always_comb begin
    found = 1'b0;
    win   = '0;
    idx   = 0;
    for (int k = 1; k <= NREQ; k++) begin
      idx = (int'(last) + k) % NREQ;
      if (!found && elig[idx]) begin
        found = 1'b1;
        win   = IDX_W'(idx);
      end
    end
  end

endmodule

// File: rtl/pcarb_start_watch.sv
module pcarb_start_watch #(
  parameter int NREQ       = 5,
  parameter int TMO_CYCLES = 16,
  parameter int IDX_W      = 3,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,     // granted, requesting and idle this cycle
  input  logic [IDX_W-1:0] cur,
  input  logic [NREQ-1:0]  req_n,
  output logic             expired,
  output logic [NREQ-1:0]  lock
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NREQ-1:0]  lock_q, lock_d;

  assign expired = tick && (cnt_q == CNT_LAST);

  always_comb begin
    if (tick && !expired) cnt_d = cnt_q + 1'b1;
    else                  cnt_d = '0;
  end

  for (genvar i = 0; i < NREQ; i++) begin : g_lock
    logic set_i;
    assign set_i     = expired && (cur == IDX_W'(i));
    // set wins over the release by a high request in the same cycle
    assign lock_d[i] = set_i | (lock_q[i] & ~req_n[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign lock = lock_q;

  // R8: counter never runs past the last window cycle
  p_cnt_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);

  // R9: a shut-out flag only appears through an expiry
  p_lock_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q[cur]) |-> $past(tick));

endmodule

// File: rtl/pci_rr_arbiter.sv
module pci_rr_arbiter
  import pcarb_pkg::*;
#(
  parameter int NREQ       = 5,
  parameter int TMO_CYCLES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arb_en,
  input  logic [NREQ-1:0] req_n,
  input  logic            frame_n,
  input  logic            irdy_n,
  output logic [NREQ-1:0] gnt_n
);

  localparam int IDX_W = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam int CNT_W = $clog2(TMO_CYCLES + 1);
  localparam logic [IDX_W-1:0] IDX_START = IDX_W'(NREQ - 1);

  logic             rst_q;
  logic             gv_q, gv_d;
  logic [IDX_W-1:0] cur_q, cur_d;
  logic [NREQ-1:0]  gnt_q, gnt_d;
  logic [NREQ-1:0]  lock, elig;
  logic             idle, cur_req, tick, expired, found;
  logic [IDX_W-1:0] win;
  arb_dec_e         dec;

  pcarb_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q)
  );

  assign idle    = frame_n & irdy_n;
  assign cur_req = ~req_n[cur_q];
  assign tick    = arb_en & gv_q & idle & cur_req;
  assign elig    = ~req_n & ~lock;

  pcarb_rr_pick #(.NREQ(NREQ), .IDX_W(IDX_W)) u_pick (
    .elig  (elig),
    .last  (cur_q),
    .found (found),
    .win   (win)
  );

  pcarb_start_watch #(
    .NREQ(NREQ), .TMO_CYCLES(TMO_CYCLES), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_watch (
    .clk     (clk),
    .rst_n   (rst_q),
    .tick    (tick),
    .cur     (cur_q),
    .req_n   (req_n),
    .expired (expired),
    .lock    (lock)
  );

  always_comb begin
    if (!arb_en)      dec = ARB_OFF;
    else if (expired) dec = ARB_EXPIRE;
    else if (tick)    dec = ARB_HOLD;
    else if (!gv_q)   dec = ARB_GRANT;
    else if (!idle)   dec = ARB_HIDDEN;
    else if (found)   dec = ARB_TURN;
    else              dec = ARB_PARK;
  end

  always_comb begin
    gv_d  = gv_q;
    cur_d = cur_q;
    unique case (dec)
      ARB_OFF, ARB_EXPIRE, ARB_TURN: gv_d = 1'b0;
      ARB_GRANT: begin
        gv_d = found;
        if (found) cur_d = win;
      end
      ARB_HIDDEN: if (found) cur_d = win;
      default: ;
    endcase
  end

  for (genvar i = 0; i < NREQ; i++) begin : g_gnt
    assign gnt_d[i] = gv_d && (cur_d == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      gv_q  <= 1'b0;
      cur_q <= IDX_START;
      gnt_q <= '0;
    end else begin
      gv_q  <= gv_d;
      cur_q <= cur_d;
      gnt_q <= gnt_d;
    end
  end

  assign gnt_n = ~gnt_q;

  // R3: never two grants at once
  p_one_grant_r3: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0(gnt_q));

  // R2: strap low clears the grants at the next edge
  p_strap_off_r2: assert property (@(posedge clk) disable iff (!rst_q)
    !arb_en |=> (gnt_q == '0));

  // R6: on an idle bus a grant only stays or drops, never swaps
  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (idle && gv_q) |=> ((gnt_q == $past(gnt_q)) || (gnt_q == '0)));

  // R7: no requests means the grant stays parked
  p_parking_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (arb_en && gv_q && (&req_n)) |=> $stable(gnt_q));

  // R9: a shut-out requester is never the grantee
  p_no_grant_locked_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (gnt_q & lock) == '0);

endmodule

// File: tb/pci_rr_arbiter_tb_top.sv
`timescale 1ns/1ps
module pci_rr_arbiter_tb_top;

  logic       clk;
  logic       rst_n;
  logic       arb_en;
  logic [4:0] req_n;
  logic       frame_n;
  logic       irdy_n;
  logic [4:0] gnt_n;

  int n_checks;
  int n_fail;
  bit done;

  // reference state
  bit       m_gv;
  int       m_cur;
  int       m_cnt;
  bit [4:0] m_lock;

  pci_rr_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .arb_en(arb_en), .req_n(req_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .gnt_n(gnt_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [4:0] m_gnt_n();
    return m_gv ? ~(5'b00001 << m_cur) : 5'h1f;
  endfunction

  task automatic model_step(bit en, bit [4:0] rq, bit fr, bit ir);
    bit idle, fnd, tk;
    bit [4:0] el, nl;
    int w;
    idle = fr & ir;
    nl   = m_lock & ~rq;
    el   = ~rq & ~m_lock;
    fnd  = 0;
    w    = 0;
    for (int k = 1; k <= 5; k++) begin
      if (!fnd && el[(m_cur + k) % 5]) begin
        fnd = 1;
        w   = (m_cur + k) % 5;
      end
    end
    tk = en && m_gv && idle && !rq[m_cur];
    if (!en) begin
      m_gv = 0; m_cnt = 0;
    end else if (tk && m_cnt == 15) begin
      m_gv = 0; nl[m_cur] = 1'b1; m_cnt = 0;
    end else if (tk) begin
      m_cnt++;
    end else begin
      m_cnt = 0;
      if (!m_gv) begin
        if (fnd) begin m_gv = 1; m_cur = w; end
      end else if (!idle) begin
        if (fnd) m_cur = w;
      end else if (fnd) begin
        m_gv = 0;
      end
    end
    m_lock = nl;
  endtask

  task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s gnt_n=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive after the falling edge, compare after the rising edge
  task automatic cyc(bit en, bit [4:0] rq, bit fr, bit ir);
    @(negedge clk);
    arb_en = en; req_n = rq; frame_n = fr; irdy_n = ir;
    @(posedge clk);
    #1;
    model_step(en, rq, fr, ir);
    chk("R3 R4 model", gnt_n, m_gnt_n());
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 0;
    m_gv = 0; m_cur = 4; m_cnt = 0; m_lock = '0;
    rst_n = 1'b0; arb_en = 1'b0; req_n = 5'h1f; frame_n = 1'b1; irdy_n = 1'b1;
    void'($urandom(32'd20240611));
    #12;
    chk("R1 in reset", gnt_n, 5'h1f);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) cyc(1'b0, 5'h1f, 1'b1, 1'b1);
    chk("R1 after reset", gnt_n, 5'h1f);

    // R4 R5: busy bus, all requesting
    cyc(1'b1, 5'h00, 1'b0, 1'b0); chk("R4 first pick 0", gnt_n, 5'b11110);
    cyc(1'b1, 5'h00, 1'b0, 1'b0); chk("R5 hidden to 1", gnt_n, 5'b11101);
    cyc(1'b1, 5'h00, 1'b0, 1'b0); chk("R4 next 2", gnt_n, 5'b11011);
    cyc(1'b1, 5'h00, 1'b0, 1'b0); chk("R4 next 3", gnt_n, 5'b10111);
    cyc(1'b1, 5'h00, 1'b0, 1'b0); chk("R4 next 4", gnt_n, 5'b01111);
    cyc(1'b1, 5'h00, 1'b0, 1'b0); chk("R4 wrap 0", gnt_n, 5'b11110);

    // R10 then R6: idle hold, then dead cycle before new grantee
    cyc(1'b1, 5'b10110, 1'b1, 1'b1); chk("R10 idle hold 0", gnt_n, 5'b11110);
    cyc(1'b1, 5'b11011, 1'b1, 1'b1); chk("R6 dead cycle", gnt_n, 5'h1f);
    cyc(1'b1, 5'b11011, 1'b1, 1'b1); chk("R6 grant 2", gnt_n, 5'b11011);

    // R7: parking with nobody requesting, idle then busy
    for (int i = 0; i < 20; i++) cyc(1'b1, 5'h1f, 1'b1, 1'b1);
    chk("R7 parked idle", gnt_n, 5'b11011);
    for (int i = 0; i < 3; i++) cyc(1'b1, 5'h1f, 1'b0, 1'b1);
    chk("R7 parked busy", gnt_n, 5'b11011);

    // R8: 16 idle requesting cycles without a start
    for (int i = 1; i <= 15; i++) cyc(1'b1, 5'b11011, 1'b1, 1'b1);
    chk("R8 still granted at 15", gnt_n, 5'b11011);
    cyc(1'b1, 5'b11011, 1'b1, 1'b1);
    chk("R8 released at 16", gnt_n, 5'h1f);

    // R9: shut out until the request is raised once
    for (int i = 0; i < 5; i++) cyc(1'b1, 5'b11011, 1'b1, 1'b1);
    chk("R9 still shut out", gnt_n, 5'h1f);
    cyc(1'b1, 5'h1f, 1'b1, 1'b1);
    chk("R9 raise cycle", gnt_n, 5'h1f);
    cyc(1'b1, 5'b11011, 1'b1, 1'b1);
    chk("R9 regranted", gnt_n, 5'b11011);

    // R2: strap off
    cyc(1'b0, 5'h00, 1'b0, 1'b0); chk("R2 off", gnt_n, 5'h1f);
    for (int i = 0; i < 3; i++) cyc(1'b0, 5'h00, 1'b1, 1'b1);
    chk("R2 stays off", gnt_n, 5'h1f);

    // random phase, checked against the reference every cycle
    begin
      bit [4:0] rq;
      bit busy, en;
      rq = 5'h1f; busy = 0; en = 1;
      for (int i = 0; i < 5000; i++) begin
        if ($urandom_range(7) == 0) begin
          for (int b = 0; b < 5; b++) rq[b] = ($urandom_range(9) >= 4);
        end
        if ($urandom_range(5) == 0) busy = ~busy;
        en = ($urandom_range(59) != 0);
        cyc(en, rq, ~busy, busy ? 1'($urandom_range(1)) : 1'b1);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule